// File: doc/BRIEF.md
# Dual-Path SPI Serial Clock Generator

This block derives the serial clock of an SPI controller from a faster source clock. Two division laws are available. The binary law divides the source by four and then by two to the power of a 3-bit exponent. The linear law divides the source by two and then by an 8-bit count plus one. A single select input picks the law. The clock always runs at half duty. While no burst runs, it rests at the programmed polarity level.

The transfer engine holds `run_i` high for the duration of a burst. The generator can hold off the first clock edge for a programmable number of source cycles, so that the chip select settles before the first edge. Each clock change comes with a one-cycle strobe, so the engine can launch and sample data without looking at the clock itself. The edge that leaves the rest level is the leading edge, and the edge that returns to it is the trailing edge.

All division and polarity settings are captured only while the block is idle. A change made in the middle of a burst therefore cannot shorten a clock phase. The block also registers three output-driver enables and raises a request that keeps the main clock running.

Top module: `spi_sclk_gen`

## Requirements
- R1: With `enh_sel_i`=0, each clock phase lasts H = 2^(N+1) source cycles, where N = `pow2_exp_i` (N=0 gives /4 and N=7 gives /512 per full period).
- R2: With `enh_sel_i`=1, each clock phase lasts H = N+1 source cycles, where N = `enh_div_i` (N=0 gives /2 and N=255 gives /512 per full period).
- R3: `enh_sel_i` alone chooses which of R1 or R2 applies. The field of the law that is not selected has no effect.
- R4: While idle, `sclk_o` equals `cpol_i` as registered one cycle earlier, and neither strobe is raised.
- R5: If `run_i` is first sampled high by an idle block at edge k, the first clock edge occurs at edge k+H+D. D = `lead_dly_i` when `lead_en_i`=1, and D = 0 otherwise. If `run_i` falls during the delay, the block returns to idle and no edge occurs.
- R6: `lead_edge_o` is high for exactly the cycle in which `sclk_o` has just left the rest level. `trail_edge_o` is high for exactly the cycle in which it has just returned. The two strobes are never high together.
- R7: When `run_i` falls while the clock is away from the rest level, the current phase completes its full H cycles and ends with a trailing strobe. After that, and in the case where `run_i` falls at rest, no further edge follows.
- R8: Changes to the division, select, polarity or lead settings while `busy_o`=1 have no effect until the block is idle again.
- R9: `mosi_oe_o`, `sclk_oe_o` and `cs_oe_o` follow `mosi_oe_en_i`, `sclk_oe_en_i` and `cs_oe_en_i` one cycle later. All three are 0 after reset.
- R10: `core_clk_on_o` is high whenever `busy_o` is high or `keep_clk_i` is high, and is low otherwise.
- R11: While a burst continues, the high and low phases of `sclk_o` both last H cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Burst active request from the transfer engine |
| cpol_i | input | 1 | Rest level of the serial clock |
| pow2_exp_i | input | POW2_W (3) | Exponent N of the binary law |
| enh_div_i | input | ENH_W (8) | Count N of the linear law |
| enh_sel_i | input | 1 | 1 selects the linear law |
| lead_dly_i | input | LEAD_W (16) | Chip-select-to-first-edge delay in source cycles |
| lead_en_i | input | 1 | Enables the lead delay |
| mosi_oe_en_i | input | 1 | Data output driver enable request |
| sclk_oe_en_i | input | 1 | Clock output driver enable request |
| cs_oe_en_i | input | 1 | Chip-select output driver enable request |
| keep_clk_i | input | 1 | Keep the main clock running while idle |
| sclk_o | output | 1 | Serial clock level |
| lead_edge_o | output | 1 | Strobe on the edge leaving the rest level |
| trail_edge_o | output | 1 | Strobe on the edge returning to the rest level |
| busy_o | output | 1 | Block is in the lead delay or is clocking |
| mosi_oe_o | output | 1 | Registered data driver enable |
| sclk_oe_o | output | 1 | Registered clock driver enable |
| cs_oe_o | output | 1 | Registered chip-select driver enable |
| core_clk_on_o | output | 1 | Main clock request |

## Verification
A wrong phase counter or a wrong captured divider shows up on the first clock edge of a burst. The bench sees it within H+D+1 cycles of raising `run_i`, because that edge arrives early or late. A phase bit that drifts from the strobes breaks the level each strobe implies at once, in the same cycle. A stop sequence that misses its exit leaves extra strobes in the quiet window after the burst, and a captured setting that leaks mid-burst changes the length of the next phase.

// File: rtl/spi_sclk_pkg.sv
`timescale 1ns/1ps
package spi_sclk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_CLK  = 2'd2
  } sclk_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/spi_sclk_shadow.sv
`timescale 1ns/1ps
// Captures the clock settings while idle and freezes them during a burst.
module spi_sclk_shadow #(
  parameter int POW2_W = 3,
  parameter int ENH_W  = 8,
  parameter int LEAD_W = 16,
  parameter int HM1_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              cpol_i,
  input  logic [POW2_W-1:0] pow2_exp_i,
  input  logic [ENH_W-1:0]  enh_div_i,
  input  logic              enh_sel_i,
  input  logic [LEAD_W-1:0] lead_dly_i,
  input  logic              lead_en_i,
  output logic [HM1_W-1:0]  hm1_o,
  output logic              cpol_o,
  output logic [LEAD_W-1:0] lead_o,
  output logic              lead_start_o
);
  logic [POW2_W:0]   pow2_sh;
  logic [HM1_W-1:0]  hm1_pow2;
  logic [HM1_W-1:0]  hm1_enh;
  logic [HM1_W-1:0]  hm1_sel;
  logic [LEAD_W-1:0] lead_eff;
  logic [HM1_W-1:0]  hm1_d,  hm1_q;
  logic              cpol_d, cpol_q;
  logic [LEAD_W-1:0] lead_d, lead_q;

  // half period minus one for the binary law: N+1 low ones
  assign pow2_sh  = {1'b0, pow2_exp_i} + (POW2_W+1)'(1);
  assign hm1_pow2 = ~({HM1_W{1'b1}} << pow2_sh);

  generate
    if (HM1_W == ENH_W) begin : g_enh_direct
      assign hm1_enh = enh_div_i;
    end else begin : g_enh_ext
      assign hm1_enh = HM1_W'(enh_div_i);
    end
  endgenerate

  assign hm1_sel      = enh_sel_i ? hm1_enh : hm1_pow2;
  assign lead_eff     = lead_en_i ? lead_dly_i : '0;
  assign lead_start_o = |lead_eff;

  always_comb begin
    hm1_d  = hm1_q;
    cpol_d = cpol_q;
    lead_d = lead_q;
    if (!busy_i) begin
      hm1_d  = hm1_sel;
      cpol_d = cpol_i;
      lead_d = lead_eff;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hm1_q  <= '0;
      cpol_q <= 1'b0;
      lead_q <= '0;
    end else begin
      hm1_q  <= hm1_d;
      cpol_q <= cpol_d;
      lead_q <= lead_d;
    end
  end

  assign hm1_o  = hm1_q;
  assign cpol_o = cpol_q;
  assign lead_o = lead_q;
endmodule

// File: rtl/spi_sclk_seq.sv
`timescale 1ns/1ps
// Lead delay, half-period counting, clock phase and edge strobes.
module spi_sclk_seq
  import spi_sclk_pkg::*;
#(
  parameter int LEAD_W = 16,
  parameter int HM1_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [HM1_W-1:0]  hm1_i,
  input  logic              cpol_i,
  input  logic [LEAD_W-1:0] lead_i,
  input  logic              lead_start_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              lead_edge_o,
  output logic              trail_edge_o
);
  sclk_state_e       state_d, state_q;
  logic [HM1_W-1:0]  cnt_d,   cnt_q;
  logic [LEAD_W-1:0] lcnt_d,  lcnt_q;
  logic              phase_d, phase_q;
  logic              lstb_d,  lstb_q;
  logic              tstb_d,  tstb_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lcnt_d  = lcnt_q;
    phase_d = phase_q;
    lstb_d  = 1'b0;
    tstb_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        phase_d = 1'b0;
        cnt_d   = '0;
        lcnt_d  = '0;
        if (run_i) state_d = lead_start_i ? ST_LEAD : ST_CLK;
      end
      ST_LEAD: begin
        if (!run_i) begin
          state_d = ST_IDLE;
          lcnt_d  = '0;
        end else if (lcnt_q == lead_i - LEAD_W'(1)) begin
          state_d = ST_CLK;
          lcnt_d  = '0;
        end else begin
          lcnt_d = lcnt_q + LEAD_W'(1);
        end
      end
      ST_CLK: begin
        if (!run_i && !phase_q) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (cnt_q == hm1_i) begin
          cnt_d   = '0;
          phase_d = ~phase_q;
          if (phase_q) begin
            tstb_d = 1'b1;
            if (!run_i) state_d = ST_IDLE;
          end else begin
            lstb_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + HM1_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lcnt_q  <= '0;
      phase_q <= 1'b0;
      lstb_q  <= 1'b0;
      tstb_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lcnt_q  <= lcnt_d;
      phase_q <= phase_d;
      lstb_q  <= lstb_d;
      tstb_q  <= tstb_d;
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign sclk_o       = phase_q ^ cpol_i;
  assign lead_edge_o  = lstb_q;
  assign trail_edge_o = tstb_q;
endmodule

// File: rtl/spi_sclk_oe.sv
`timescale 1ns/1ps
// Registered driver enables and main clock request.
module spi_sclk_oe #(
  parameter int NUM_OE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_OE-1:0] oe_en_i,
  input  logic              busy_i,
  input  logic              keep_clk_i,
  output logic [NUM_OE-1:0] oe_o,
  output logic              clk_on_o
);
  for (genvar i = 0; i < NUM_OE; i++) begin : g_oe
    logic oe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) oe_q <= 1'b0;
      else         oe_q <= oe_en_i[i];
    end
    assign oe_o[i] = oe_q;
  end

  assign clk_on_o = busy_i | keep_clk_i;
endmodule

// File: rtl/spi_sclk_gen.sv
`timescale 1ns/1ps
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int POW2_W = 3,
  parameter int ENH_W  = 8,
  parameter int LEAD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cpol_i,
  input  logic [POW2_W-1:0] pow2_exp_i,
  input  logic [ENH_W-1:0]  enh_div_i,
  input  logic              enh_sel_i,
  input  logic [LEAD_W-1:0] lead_dly_i,
  input  logic              lead_en_i,
  input  logic              mosi_oe_en_i,
  input  logic              sclk_oe_en_i,
  input  logic              cs_oe_en_i,
  input  logic              keep_clk_i,
  output logic              sclk_o,
  output logic              lead_edge_o,
  output logic              trail_edge_o,
  output logic              busy_o,
  output logic              mosi_oe_o,
  output logic              sclk_oe_o,
  output logic              cs_oe_o,
  output logic              core_clk_on_o
);
  localparam int HM1_W  = max_int(2 ** POW2_W, ENH_W);
  localparam int NUM_OE = 3;

  logic [HM1_W-1:0]  hm1_q;
  logic              cpol_q;
  logic [LEAD_W-1:0] lead_q;
  logic              lead_start;
  logic              busy;
  logic [NUM_OE-1:0] oe_vec;

  spi_sclk_shadow #(
    .POW2_W(POW2_W), .ENH_W(ENH_W), .LEAD_W(LEAD_W), .HM1_W(HM1_W)
  ) u_shadow (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy),
    .cpol_i       (cpol_i),
    .pow2_exp_i   (pow2_exp_i),
    .enh_div_i    (enh_div_i),
    .enh_sel_i    (enh_sel_i),
    .lead_dly_i   (lead_dly_i),
    .lead_en_i    (lead_en_i),
    .hm1_o        (hm1_q),
    .cpol_o       (cpol_q),
    .lead_o       (lead_q),
    .lead_start_o (lead_start)
  );

  spi_sclk_seq #(
    .LEAD_W(LEAD_W), .HM1_W(HM1_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .hm1_i        (hm1_q),
    .cpol_i       (cpol_q),
    .lead_i       (lead_q),
    .lead_start_i (lead_start),
    .busy_o       (busy),
    .sclk_o       (sclk_o),
    .lead_edge_o  (lead_edge_o),
    .trail_edge_o (trail_edge_o)
  );

  spi_sclk_oe #(
    .NUM_OE(NUM_OE)
  ) u_oe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .oe_en_i    ({cs_oe_en_i, sclk_oe_en_i, mosi_oe_en_i}),
    .busy_i     (busy),
    .keep_clk_i (keep_clk_i),
    .oe_o       (oe_vec),
    .clk_on_o   (core_clk_on_o)
  );

  assign busy_o    = busy;
  assign mosi_oe_o = oe_vec[0];
  assign sclk_oe_o = oe_vec[1];
  assign cs_oe_o   = oe_vec[2];
endmodule

// File: rtl/spi_sclk_gen_chk.sv
`timescale 1ns/1ps
module spi_sclk_gen_chk #(
  parameter int HM1_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy,
  input logic             cpol_q,
  input logic [HM1_W-1:0] hm1_q,
  input logic             sclk_o,
  input logic             lead_edge_o,
  input logic             trail_edge_o,
  input logic             keep_clk_i,
  input logic             core_clk_on_o,
  input logic             mosi_oe_en_i,
  input logic             mosi_oe_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_edge_o && trail_edge_o)); // R6
  AST_LEAD_LEAVES_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_edge_o |-> (sclk_o != cpol_q)); // R6
  AST_TRAIL_AT_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_edge_o |-> (sclk_o == cpol_q)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !$past(busy)) |-> (!lead_edge_o && !trail_edge_o)); // R4
  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (sclk_o == cpol_q)); // R4
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(hm1_q)); // R8
  AST_LEVEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && !lead_edge_o && !trail_edge_o) |-> $stable(sclk_o)); // R11
  AST_CLK_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy || keep_clk_i) |-> core_clk_on_o); // R10
  AST_OE_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mosi_oe_o == $past(mosi_oe_en_i)); // R9
endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.HM1_W(HM1_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy          (busy),
  .cpol_q        (cpol_q),
  .hm1_q         (hm1_q),
  .sclk_o        (sclk_o),
  .lead_edge_o   (lead_edge_o),
  .trail_edge_o  (trail_edge_o),
  .keep_clk_i    (keep_clk_i),
  .core_clk_on_o (core_clk_on_o),
  .mosi_oe_en_i  (mosi_oe_en_i),
  .mosi_oe_o     (mosi_oe_o)
);

// File: tb/spi_sclk_gen_test.sv
`timescale 1ns/1ps
module spi_sclk_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        cpol = 1'b0;
  logic [2:0]  pow2_exp = '0;
  logic [7:0]  enh_div = '0;
  logic        enh_sel = 1'b0;
  logic [15:0] lead_dly = '0;
  logic        lead_en = 1'b0;
  logic        mosi_en = 1'b0, sclk_en = 1'b0, cs_en = 1'b0;
  logic        keep = 1'b0;
  logic        sclk, lead_e, trail_e, busy, mosi_oe, sclk_oe, cs_oe, clk_on;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_sclk_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cpol_i(cpol),
    .pow2_exp_i(pow2_exp), .enh_div_i(enh_div), .enh_sel_i(enh_sel),
    .lead_dly_i(lead_dly), .lead_en_i(lead_en),
    .mosi_oe_en_i(mosi_en), .sclk_oe_en_i(sclk_en), .cs_oe_en_i(cs_en),
    .keep_clk_i(keep), .sclk_o(sclk), .lead_edge_o(lead_e),
    .trail_edge_o(trail_e), .busy_o(busy), .mosi_oe_o(mosi_oe),
    .sclk_oe_o(sclk_oe), .cs_oe_o(cs_oe), .core_clk_on_o(clk_on)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wait_edge(input bit want_trail, output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!(want_trail ? trail_e : lead_e) && n < 5000);
  endtask

  task automatic quiet(input int cycles, input bit pol);
    int strobes = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      if (lead_e || trail_e) strobes++;
    end
    chk("R7 no edge after stop", strobes, 0);
    chk("R4 rest level", sclk, pol);
    chk("R4 idle busy", busy, 0);
  endtask

  task automatic burst(input string rq, input int h, input int d, input bit pol, input int pairs);
    int n;
    @(negedge clk); run = 1'b1;
    wait_edge(1'b0, n);
    chk("R5 first edge", n, d + h + 1);
    chk("R6 lead level", sclk, !pol);
    chk("R10 clock request", clk_on, 1);
    for (int p = 0; p < pairs; p++) begin
      wait_edge(1'b1, n);
      chk({rq, " high phase"}, n, h);
      chk("R11 trail level", sclk, pol);
      if (p < pairs - 1) begin
        wait_edge(1'b0, n);
        chk({rq, " low phase"}, n, h);
      end
    end
    @(negedge clk); run = 1'b0;
    quiet(2 * h + 4, pol);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    // R4 / R9 / R10 reset state
    chk("R4 reset level", sclk, 0);
    chk("R4 reset strobes", lead_e | trail_e, 0);
    chk("R9 reset enables", {mosi_oe, sclk_oe, cs_oe}, 0);
    chk("R10 idle request", clk_on, 0);
    @(negedge clk); cpol = 1'b1;
    repeat (2) @(posedge clk); #1;
    chk("R4 polarity follows", sclk, 1);

    // R9 driver enables, one cycle later
    @(negedge clk); mosi_en = 1; sclk_en = 0; cs_en = 1;
    chk("R9 not yet", {cs_oe, sclk_oe, mosi_oe}, 0);
    @(posedge clk); #1;
    chk("R9 enables", {cs_oe, sclk_oe, mosi_oe}, 3'b101);
    @(negedge clk); mosi_en = 0; sclk_en = 1; cs_en = 0;
    @(posedge clk); #1;
    chk("R9 enables", {cs_oe, sclk_oe, mosi_oe}, 3'b010);

    // R10 keep request
    @(negedge clk); keep = 1'b1; #1;
    chk("R10 keep", clk_on, 1);
    @(negedge clk); keep = 1'b0; #1;
    chk("R10 keep off", clk_on, 0);

    // R1 binary law sweep; R3: linear field set to junk, R5: lead ignored when disabled
    enh_sel = 1'b0; enh_div = 8'd77; lead_dly = 16'd5; lead_en = 1'b0;
    for (int pol = 0; pol < 2; pol++) begin
      for (int e = 0; e < 8; e++) begin
        @(negedge clk); cpol = pol[0]; pow2_exp = e[2:0];
        repeat (2) @(posedge clk);
        burst("R1", 1 << (e + 1), 0, pol[0], 2);
      end
    end

    // R2 linear law sweep with lead delay; R3: binary field set to junk
    enh_sel = 1'b1; pow2_exp = 3'd6; lead_en = 1'b1;
    for (int k = 0; k < 11; k++) begin
      automatic int nv = (k < 9) ? k : ((k == 9) ? 99 : 255);
      automatic int dv = k % 3 == 2 ? 3 : k % 3;
      @(negedge clk); enh_div = nv[7:0]; lead_dly = dv[15:0]; cpol = k[0];
      repeat (2) @(posedge clk);
      burst("R2", nv + 1, dv, k[0], (nv > 50) ? 1 : 3);
    end

    // R3 switching path select between bursts
    @(negedge clk); enh_sel = 1'b0; pow2_exp = 3'd1; enh_div = 8'd2; lead_en = 1'b0; cpol = 1'b0;
    repeat (2) @(posedge clk);
    burst("R3 binary", 4, 0, 1'b0, 2);
    @(negedge clk); enh_sel = 1'b1;
    repeat (2) @(posedge clk);
    burst("R3 linear", 3, 0, 1'b0, 2);

    // R8 settings changed mid-burst are ignored
    @(negedge clk); enh_sel = 1'b1; enh_div = 8'd3; cpol = 1'b0; lead_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); run = 1'b1;
    wait_edge(1'b0, n);
    chk("R8 first edge", n, 5);
    @(negedge clk); enh_div = 8'd9; enh_sel = 1'b0; pow2_exp = 3'd7; cpol = 1'b1;
    lead_en = 1'b1; lead_dly = 16'd40;
    wait_edge(1'b1, n);
    chk("R8 phase kept", n, 4);
    chk("R8 polarity kept", sclk, 0);
    wait_edge(1'b0, n);
    chk("R8 phase kept", n, 4);
    wait_edge(1'b1, n);
    chk("R8 phase kept", n, 4);
    @(negedge clk); run = 1'b0; pow2_exp = 3'd0; lead_en = 1'b0;
    quiet(12, 1'b1);
    burst("R8 new setting", 2, 0, 1'b1, 2);

    // R7 run dropped while away from rest level
    @(negedge clk); enh_sel = 1'b1; enh_div = 8'd5; cpol = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); run = 1'b1;
    wait_edge(1'b0, n);
    chk("R5 first edge", n, 7);
    @(negedge clk); run = 1'b0;
    wait_edge(1'b1, n);
    chk("R7 phase completes", n, 6);
    chk("R7 back at rest", sclk, 0);
    quiet(20, 1'b0);

    // R5 run dropped during the lead delay
    @(negedge clk); enh_div = 8'd1; lead_en = 1'b1; lead_dly = 16'd50;
    repeat (2) @(posedge clk);
    @(negedge clk); run = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk); run = 1'b0;
    quiet(60, 1'b0);
    // R5 long lead delay, full timing
    burst("R5 long lead", 2, 50, 1'b0, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule